// File: doc/BRIEF.md
# Shared-Bus Mastership Requester

This block lives inside a device that occasionally needs to borrow a shared bus from its current owner, for example a DMA engine. It uses a three-wire protocol: an active-low bus request line, an active-low grant line from the arbiter, and a shared active-low grant-acknowledge line. The grant-acknowledge line is wired: any master may pull it low, and nobody drives it high. When the local logic asks for the bus, the block raises the request and waits for the grant. It then waits until the previous master has finished its cycle and the previous slave has let go of the bus. Only after that does it claim mastership by pulling the acknowledge line low.

While it holds the acknowledge line, the local logic sees an "owns bus" indication and runs its own transfers. When those transfers finish, the local logic signals done. The block then releases the acknowledge line and returns to idle. The arbiter's inputs, the address strobe, the transfer acknowledge and the grant-acknowledge line are all asynchronous to this block. Each passes through a two-flop synchronizer before any decision uses it. A static configuration input can leave the transfer acknowledge out of the release check. In that case only the address strobe and the grant-acknowledge line are tested.

Top module: `bus_borrow_requester`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `bus_req_n_o` is 1, `grant_ack_pull_o` is 0 and `owns_bus_o` is 0.
- R2: In idle, `local_req_i` high at a rising edge makes `bus_req_n_o` go to 0 right after that edge.
- R3: Mastership (`grant_ack_pull_o` = 1) is claimed only when four conditions all hold at the synchronizer outputs: grant is present (`bus_grant_n_i` = 0), address strobe is negated (`addr_strobe_n_i` = 1), transfer acknowledge is negated (`xfer_ack_n_i` = 1) and the grant-acknowledge line is negated (`grant_ack_n_i` = 1).
- R4: Mastership is never claimed while the synchronized address strobe is asserted, even when every other condition holds.
- R5: With `ignore_xack_i` = 1, the transfer acknowledge is left out of the release check, so an asserted `xfer_ack_n_i` = 0 does not block the claim.
- R6: `bus_req_n_o` stays 0 on the cycle in which `grant_ack_pull_o` first rises, and returns to 1 exactly one cycle later. It never returns to 1 before the claim.
- R7: `grant_ack_pull_o` stays 1 until `cycles_done_i` is sampled high. It falls right after that edge, and the block then returns to idle with `bus_req_n_o` at 1.
- R8: If the grant is withdrawn while the block is waiting for the bus to be released, the block goes back to requesting. It does not claim, and `bus_req_n_o` stays 0.
- R9: `local_req_i` is accepted only in idle. A request pulse seen while the block owns the bus leaves no pending request behind after the release.
- R10: `owns_bus_o` always equals `grant_ack_pull_o`.
- R11: Each asynchronous input goes through two synchronizer flops. A change that completes the release condition before edge k shows up at `grant_ack_pull_o` right after edge k+2 and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| local_req_i | input | 1 | Local logic wants the bus (sampled in idle only) |
| cycles_done_i | input | 1 | Local logic has finished all of its bus cycles |
| ignore_xack_i | input | 1 | Static option: 1 leaves the transfer acknowledge out of the release check |
| bus_grant_n_i | input | 1 | Arbiter grant, active low, asynchronous |
| addr_strobe_n_i | input | 1 | Shared address strobe, active low, asynchronous |
| xfer_ack_n_i | input | 1 | Shared transfer acknowledge, active low, asynchronous |
| grant_ack_n_i | input | 1 | Sensed level of the wired grant-acknowledge line, active low |
| bus_req_n_o | output | 1 | Bus request to the arbiter, active low, registered |
| grant_ack_pull_o | output | 1 | 1 pulls the wired grant-acknowledge line low; 0 leaves it released |
| owns_bus_o | output | 1 | Block holds mastership; local bus cycles may run |

## Verification
The bench holds each release condition asserted in turn (strobe, transfer acknowledge, another master's grant acknowledge) while the other conditions are met. A design that claimed on a partial check would pull the line while the previous owner still drives the bus. It also drops the grant during the release wait, where a faulty design would claim anyway or drop its request. It flips the transfer-acknowledge option and checks that the claim is released exactly when the option allows. It also probes the exact synchronizer latency and the one-cycle gap before the request is removed. A shortened synchronizer, or a request dropped together with the claim, shows up there as an early or missing edge. Finally, it sends a request pulse while the block owns the bus. A design that latched it would re-request after the release.

// File: rtl/bbr_pkg.sv
package bbr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_REQUEST  = 3'd1,
    ST_WAIT_REL = 3'd2,
    ST_OWN      = 3'd3,
    ST_RELEASE  = 3'd4
  } bbr_state_e;

  // positions of the asynchronous lines in the synchronizer vector
  localparam int unsigned LN_GRANT  = 0;
  localparam int unsigned LN_STROBE = 1;
  localparam int unsigned LN_XACK   = 2;
  localparam int unsigned LN_GACK   = 3;
  localparam int unsigned LN_COUNT  = 4;

endpackage

// File: rtl/bbr_sync.sv
module bbr_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  localparam int unsigned DEPTH = (STAGES < 2) ? 2 : STAGES;

  logic [WIDTH-1:0] chain_q [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < DEPTH; s++) chain_q[s] <= RESET_VAL;
    end else begin
      chain_q[0] <= async_i;
      for (int s = 1; s < DEPTH; s++) chain_q[s] <= chain_q[s-1];
    end
  end

  assign sync_o = chain_q[DEPTH-1];

endmodule

// File: rtl/bbr_release_check.sv
module bbr_release_check (
  input  logic strobe_act_i,
  input  logic xack_act_i,
  input  logic gack_act_i,
  input  logic ignore_xack_i,
  output logic bus_free_o
);

  logic xack_blocks;

  always_comb begin
    xack_blocks = xack_act_i & ~ignore_xack_i;
    bus_free_o  = ~strobe_act_i & ~gack_act_i & ~xack_blocks;
  end

endmodule

// File: rtl/bbr_fsm.sv
module bbr_fsm
  import bbr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       local_req_i,
  input  logic       cycles_done_i,
  input  logic       grant_act_i,
  input  logic       bus_free_i,
  output bbr_state_e state_o,
  output logic       req_n_o,
  output logic       pull_o
);

  bbr_state_e state_q, state_d;
  logic       req_n_q, pull_q;
  logic       req_n_d, pull_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (local_req_i) state_d = ST_REQUEST;
      ST_REQUEST:  if (grant_act_i) state_d = ST_WAIT_REL;
      ST_WAIT_REL: begin
        if (!grant_act_i)    state_d = ST_REQUEST;
        else if (bus_free_i) state_d = ST_OWN;
      end
      ST_OWN:      if (cycles_done_i) state_d = ST_RELEASE;
      ST_RELEASE:  state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  // request stays asserted through the first cycle of ownership
  always_comb begin
    pull_d  = (state_d == ST_OWN);
    req_n_d = 1'b1;
    if (state_d == ST_REQUEST || state_d == ST_WAIT_REL) req_n_d = 1'b0;
    if (state_d == ST_OWN && state_q != ST_OWN)          req_n_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      req_n_q <= 1'b1;
      pull_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      req_n_q <= req_n_d;
      pull_q  <= pull_d;
    end
  end

  assign state_o = state_q;
  assign req_n_o = req_n_q;
  assign pull_o  = pull_q;

endmodule

// File: rtl/bus_borrow_requester.sv
module bus_borrow_requester
  import bbr_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic local_req_i,
  input  logic cycles_done_i,
  input  logic ignore_xack_i,
  input  logic bus_grant_n_i,
  input  logic addr_strobe_n_i,
  input  logic xfer_ack_n_i,
  input  logic grant_ack_n_i,
  output logic bus_req_n_o,
  output logic grant_ack_pull_o,
  output logic owns_bus_o
);

  logic [LN_COUNT-1:0] raw_n, sync_n;
  logic grant_act, strobe_act, xack_act, gack_act;
  logic bus_free;
  bbr_state_e fsm_state;
  logic pull;

  always_comb begin
    raw_n            = '1;
    raw_n[LN_GRANT]  = bus_grant_n_i;
    raw_n[LN_STROBE] = addr_strobe_n_i;
    raw_n[LN_XACK]   = xfer_ack_n_i;
    raw_n[LN_GACK]   = grant_ack_n_i;
  end

  bbr_sync #(
    .WIDTH    (LN_COUNT),
    .STAGES   (SYNC_STAGES),
    .RESET_VAL({LN_COUNT{1'b1}})
  ) sync_i (
    .clk    (clk),
    .rst    (rst),
    .async_i(raw_n),
    .sync_o (sync_n)
  );

  assign grant_act  = ~sync_n[LN_GRANT];
  assign strobe_act = ~sync_n[LN_STROBE];
  assign xack_act   = ~sync_n[LN_XACK];
  assign gack_act   = ~sync_n[LN_GACK];

  bbr_release_check chk_free_i (
    .strobe_act_i (strobe_act),
    .xack_act_i   (xack_act),
    .gack_act_i   (gack_act),
    .ignore_xack_i(ignore_xack_i),
    .bus_free_o   (bus_free)
  );

  bbr_fsm fsm_i (
    .clk          (clk),
    .rst          (rst),
    .local_req_i  (local_req_i),
    .cycles_done_i(cycles_done_i),
    .grant_act_i  (grant_act),
    .bus_free_i   (bus_free),
    .state_o      (fsm_state),
    .req_n_o      (bus_req_n_o),
    .pull_o       (pull)
  );

  assign grant_ack_pull_o = pull;
  assign owns_bus_o       = pull;

endmodule

// File: rtl/bbr_checker.sv
module bbr_checker
  import bbr_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       cycles_done_i,
  input logic       ignore_xack_i,
  input logic       bus_req_n_o,
  input logic       grant_ack_pull_o,
  input logic       owns_bus_o,
  input logic       grant_act,
  input logic       strobe_act,
  input logic       xack_act,
  input logic       gack_act,
  input bbr_state_e fsm_state
);

  AST_CLAIM_ALL_FREE: assert property (@(posedge clk) disable iff (rst)
    $rose(grant_ack_pull_o) |-> $past(grant_act && !gack_act && (ignore_xack_i || !xack_act))); // R3

  AST_NO_CLAIM_STROBE: assert property (@(posedge clk) disable iff (rst)
    $rose(grant_ack_pull_o) |-> !$past(strobe_act)); // R4

  AST_REQ_DROP_AFTER_CLAIM: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_req_n_o) |-> $past(grant_ack_pull_o)); // R6

  AST_HOLD_UNTIL_DONE: assert property (@(posedge clk) disable iff (rst)
    $fell(grant_ack_pull_o) |-> $past(cycles_done_i)); // R7

  AST_GRANT_LOST_RETREAT: assert property (@(posedge clk) disable iff (rst)
    (fsm_state == ST_WAIT_REL && !grant_act) |=> (!grant_ack_pull_o && !bus_req_n_o)); // R8

  AST_REQ_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_req_n_o) |-> $past(fsm_state == ST_IDLE)); // R9

  AST_OWNS_TRACKS_PULL: assert property (@(posedge clk) disable iff (rst)
    owns_bus_o == grant_ack_pull_o); // R10

endmodule

bind bus_borrow_requester bbr_checker chk_i (
  .clk             (clk),
  .rst             (rst),
  .cycles_done_i   (cycles_done_i),
  .ignore_xack_i   (ignore_xack_i),
  .bus_req_n_o     (bus_req_n_o),
  .grant_ack_pull_o(grant_ack_pull_o),
  .owns_bus_o      (owns_bus_o),
  .grant_act       (grant_act),
  .strobe_act      (strobe_act),
  .xack_act        (xack_act),
  .gack_act        (gack_act),
  .fsm_state       (fsm_state)
);

// File: tb/bus_borrow_requester_tb_top.sv
`timescale 1ns/1ps
module bus_borrow_requester_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic local_req = 1'b0, cycles_done = 1'b0, ignore_xack = 1'b0;
  logic grant_n = 1'b1, strobe_n = 1'b1, xack_n = 1'b1, other_gack = 1'b0;
  logic gack_line_n;
  logic bus_req_n, pull, owns;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  // wired grant-acknowledge line: low when anyone pulls
  assign gack_line_n = ~(pull | other_gack);

  bus_borrow_requester dut_i (
    .clk             (clk),
    .rst             (rst),
    .local_req_i     (local_req),
    .cycles_done_i   (cycles_done),
    .ignore_xack_i   (ignore_xack),
    .bus_grant_n_i   (grant_n),
    .addr_strobe_n_i (strobe_n),
    .xfer_ack_n_i    (xack_n),
    .grant_ack_n_i   (gack_line_n),
    .bus_req_n_o     (bus_req_n),
    .grant_ack_pull_o(pull),
    .owns_bus_o      (owns)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic pulse_req();
    local_req = 1'b1;
    step(1);
    local_req = 1'b0;
  endtask

  task automatic finish_cycles();
    cycles_done = 1'b1;
    step(1);
    cycles_done = 1'b0;
  endtask

  task automatic t_reset();
    step(3);
    check("R1", "req_n in reset", bus_req_n, 1'b1);
    check("R1", "pull in reset", pull, 1'b0);
    rst = 1'b0;
    step(1);
    check("R1", "req_n after reset", bus_req_n, 1'b1);
    check("R1", "owns after reset", owns, 1'b0);
  endtask

  task automatic t_full_release();
    pulse_req();
    check("R2", "req_n after local request", bus_req_n, 1'b0);
    strobe_n = 1'b0; xack_n = 1'b0; other_gack = 1'b1; grant_n = 1'b0;
    step(6);
    check("R4", "no claim while strobe busy", pull, 1'b0);
    strobe_n = 1'b1;
    step(6);
    check("R3", "no claim while xfer ack asserted", pull, 1'b0);
    xack_n = 1'b1;
    step(6);
    check("R3", "no claim while other master acks", pull, 1'b0);
    other_gack = 1'b0;
    step(2);
    check("R11", "claim not before third edge", pull, 1'b0);
    step(1);
    check("R11", "claim at third edge", pull, 1'b1);
    check("R6", "request held on claim cycle", bus_req_n, 1'b0);
    check("R10", "owns follows pull", owns, 1'b1);
    step(1);
    check("R6", "request dropped one cycle later", bus_req_n, 1'b1);
    grant_n = 1'b1;
    step(8);
    check("R7", "pull held until done", pull, 1'b1);
    finish_cycles();
    check("R7", "pull released after done", pull, 1'b0);
    check("R10", "owns released", owns, 1'b0);
    step(3);
    check("R7", "idle with request off", bus_req_n, 1'b1);
  endtask

  task automatic t_ignore_xack();
    ignore_xack = 1'b1; xack_n = 1'b0;
    pulse_req();
    grant_n = 1'b0;
    step(6);
    check("R5", "claim with xfer ack ignored", pull, 1'b1);
    grant_n = 1'b1;
    finish_cycles();
    step(3);
    ignore_xack = 1'b0; xack_n = 1'b1;
    check("R5", "released after ignored-ack run", pull, 1'b0);
  endtask

  task automatic t_grant_lost();
    pulse_req();
    strobe_n = 1'b0; grant_n = 1'b0;
    step(6);
    grant_n = 1'b1;
    step(4);
    strobe_n = 1'b1;
    step(6);
    check("R8", "no claim after grant lost", pull, 1'b0);
    check("R8", "request kept after grant lost", bus_req_n, 1'b0);
    grant_n = 1'b0;
    step(6);
    check("R8", "claim after grant returns", pull, 1'b1);
    pulse_req();
    grant_n = 1'b1;
    finish_cycles();
    step(6);
    check("R9", "request pulse while owning ignored", bus_req_n, 1'b1);
    check("R9", "no second claim", pull, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_full_release();
    t_ignore_xack();
    t_grant_lost();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule